// File: doc/BRIEF.md
# SMBus Target with Alert Response

This block is the serial host interface of a register-mapped monitoring device. A host reaches an internal register file over the two open-drain wires SCL and SDA. It writes a pointer byte and then data bytes, and it reads bytes starting at the pointer. The block samples both wires on its own system clock and only ever pulls SDA low. It never drives SCL.

Condition bits from the monitoring logic are latched into a status register. Any latched bit whose mask bit is set pulls the shared, wired-AND alert line low. A host that sees the line low issues a read to the alert response address. Every alerting target then returns its own address, and open-drain arbitration on SDA leaves only the lowest address on the wire. A target that loses arbitration keeps its alert pending. The alert is withdrawn only after the host has read the status register and the condition has gone away. A bus-inactivity timer frees SDA if a transaction stalls, and this timer can be switched off. A sticky lock bit freezes the configuration and mask registers until reset.

Top module: `smb_alert_target`

## Requirements
- R1: After reset, SDA and the alert line are released. The config register (0x40) reads 0x00 and the mask register (0x42) reads 0xFF.
- R2: In a write transaction addressed to the device address (default 0x2E, R/W bit 0), the first data byte sets the register pointer and each later byte is written at the pointer. Each of these bytes is acknowledged, and the pointer steps by one after each write.
- R3: A read (R/W bit 1) returns the byte at the pointer, MSB first, and the pointer steps by one after every byte sent. Registers 0x20..0x24 return bytes 0..4 of the result input, and writes to them have no effect. Unmapped addresses read 0x00.
- R4: An address byte that names neither the device nor an acknowledgeable alert response read is not acknowledged.
- R5: A status input bit that is 1 sets the matching latched bit in 0x41. The alert output is driven while any latched bit has its mask bit (0x42) set. Latched bits whose mask bit is 0 do not drive it.
- R6: A read of address 0x0C is acknowledged only while the alert is driven. It returns the data byte {device address, 0}.
- R7: While sending, if the block puts out a 1 and samples SDA low on the rising SCL edge, it releases SDA for the rest of the byte, and its alert stays asserted.
- R8: The alert stays asserted after an alert response and after the condition input drops. A read of 0x41 returns the latched bits and then keeps only those bits whose inputs are still 1.
- R9: If a transaction shows no SCL or SDA edge for 35 ms (CLK_HZ/1000*35 clock cycles), the block releases SDA and returns to idle.
- R10: With config bit 6 set to 1, the inactivity timeout is disabled.
- R11: Writing 1 to config bit 1 sets a lock. After that, writes to 0x40 and 0x42 are ignored until reset. The config register reads back only bits 6 and 1; its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL wire |
| sda_i | input | 1 | Sensed level of the SDA wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| alert_oe | output | 1 | 1 pulls the shared alert line low |
| status_in | input | 8 | Condition bits from the monitoring logic |
| result_in | input | NRES*8 | Measurement bytes shown at 0x20 upward |

## Verification
The assertions rely on three things about the bus. The host changes SDA only while SCL is low, except at START and STOP. SCL and SDA stay stable for many system clocks between edges. Register writes arrive only during bus activity, so they cannot coincide with a timeout. The bench keeps to these conditions: its host model moves one wire at a time, holding each level for a fixed quarter-bit of clock cycles. The rival target's bits are set in the same SCL-low window that the block uses.

// File: rtl/smb_pkg.sv
// Package: shared types and constants for the SMBus target.
// Assumes: 7-bit addressing only.
package smb_pkg;
    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_WR,
        LS_RD,
        LS_HOLD
    } link_st_t;

    localparam logic [6:0] ARA_ADDR = 7'h0C;
endpackage

// File: rtl/smb_bus_sync.sv
// Module: synchronises SCL/SDA into the clock domain and derives the bus events.
// Assumes: wire levels are held for several clocks between changes.
module smb_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic edge_ev
);
    logic scl_m, scl_s, scl_q, sda_m, sda_q;

    // two-stage synchroniser plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_q} <= 3'b111;
            {sda_m, sda_s, sda_q} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_q} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_q} <= {sda_i, sda_m, sda_s};
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    assign edge_ev  = (scl_s ^ scl_q) | (sda_s ^ sda_q);
endmodule

// File: rtl/smb_timeout.sv
// Module: bus-inactivity timer; one-cycle pulse after LIMIT quiet cycles.
// Assumes: busy is high from START to STOP/timeout; any wire edge restarts it.
module smb_timeout #(
    parameter int LIMIT = 1750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic edge_ev,
    input  logic enable,
    output logic tmo_ev
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // count quiet cycles while a transaction is open
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || edge_ev || !enable) begin
            cnt    <= '0;
            tmo_ev <= 1'b0;
        end else if (cnt == CW'(LIMIT - 1)) begin
            cnt    <= '0;
            tmo_ev <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tmo_ev <= 1'b0;
        end
    end
endmodule

// File: rtl/smb_regs.sv
// Module: register file - results, config (timeout off, lock), latched status, mask.
// Assumes: one write strobe per byte; stat_rd pulses when the status byte is loaded.
module smb_regs #(
    parameter int         NRES      = 5,
    parameter logic [7:0] RES_BASE  = 8'h20,
    parameter logic [7:0] CFG_ADDR  = 8'h40,
    parameter logic [7:0] STAT_ADDR = 8'h41,
    parameter logic [7:0] MASK_ADDR = 8'h42
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      rd_addr,
    input  logic            stat_rd,
    input  logic [7:0]      status_in,
    input  logic [NRES*8-1:0] result_in,
    output logic [7:0]      rd_data,
    output logic            alert,
    output logic            tmo_dis,
    output logic            cfg_lock
);
    logic [7:0] mask_q, latched;

    // writable registers, frozen once the lock is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_dis  <= 1'b0;
            cfg_lock <= 1'b0;
            mask_q   <= 8'hFF;
        end else if (wr_en && !cfg_lock) begin
            if (wr_addr == CFG_ADDR) begin
                tmo_dis  <= wr_data[6];
                cfg_lock <= wr_data[1];
            end
            if (wr_addr == MASK_ADDR) mask_q <= wr_data;
        end
    end

    // status latch: set by inputs, reduced to live inputs after a status read
    always_ff @(posedge clk) begin
        if (!rst_n) latched <= 8'h00;
        else        latched <= (stat_rd ? 8'h00 : latched) | status_in;
    end

    assign alert = |(latched & mask_q);

    // read multiplexer
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NRES; i++)
            if (rd_addr == RES_BASE + 8'(i)) rd_data = result_in[i*8 +: 8];
        if (rd_addr == CFG_ADDR)  rd_data = {1'b0, tmo_dis, 4'b0000, cfg_lock, 1'b0};
        if (rd_addr == STAT_ADDR) rd_data = latched;
        if (rd_addr == MASK_ADDR) rd_data = mask_q;
    end
endmodule

// File: rtl/smb_link.sv
// Module: byte-level SMBus target engine - address match, pointer/data writes,
//         auto-increment reads, alert response with bitwise arbitration.
// Assumes: events come from smb_bus_sync; DEV_ADDR differs from the alert address.
module smb_link
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h2E,
    parameter logic [7:0] STAT_ADDR = 8'h41
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       tmo_ev,
    input  logic       alert,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       busy,
    output logic       wr_en,
    output logic       stat_rd,
    output logic [7:0] ptr,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    link_st_t   st;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txb, next_tx;
    logic       is_read, is_ara, first_wr, addr_hit;

    assign addr_hit = (shreg[7:1] == DEV_ADDR) ||
                      ((shreg[7:1] == ARA_ADDR) && shreg[0] && alert);
    assign next_tx  = is_ara ? {DEV_ADDR, 1'b0} : rd_data;

    // protocol sequencer: bus events first, then SCL rise sampling, then SCL fall driving
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LS_IDLE; bitcnt <= '0; shreg <= '0; txb <= '0; ptr <= '0;
            wr_addr <= '0; wr_data <= '0; wr_en <= 1'b0; stat_rd <= 1'b0;
            sda_oe <= 1'b0; busy <= 1'b0; is_read <= 1'b0; is_ara <= 1'b0;
            first_wr <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            stat_rd <= 1'b0;
            if (tmo_ev) begin
                st <= LS_IDLE; sda_oe <= 1'b0; busy <= 1'b0;
            end else if (start_ev) begin
                st <= LS_ADDR; bitcnt <= '0; sda_oe <= 1'b0; busy <= 1'b1;
            end else if (stop_ev) begin
                st <= LS_IDLE; sda_oe <= 1'b0; busy <= 1'b0;
            end else if (scl_rise) begin
                if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
                shreg <= {shreg[6:0], sda_s};
                if (st == LS_RD) begin
                    txb <= {txb[6:0], 1'b0};
                    if (bitcnt < 4'd8 && txb[7] && !sda_s) begin
                        st     <= LS_HOLD;
                        sda_oe <= 1'b0;
                    end
                end
            end else if (scl_fall) begin
                case (st)
                    LS_ADDR: begin
                        if (bitcnt == 4'd8) begin
                            if (addr_hit) begin
                                sda_oe  <= 1'b1;
                                is_read <= shreg[0];
                                is_ara  <= (shreg[7:1] == ARA_ADDR);
                            end else begin
                                st <= LS_HOLD;
                            end
                        end else if (bitcnt == 4'd9) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                st      <= LS_RD;
                                txb     <= next_tx;
                                sda_oe  <= ~next_tx[7];
                                stat_rd <= !is_ara && (ptr == STAT_ADDR);
                            end else begin
                                st       <= LS_WR;
                                sda_oe   <= 1'b0;
                                first_wr <= 1'b1;
                            end
                        end
                    end
                    LS_WR: begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            if (first_wr) begin
                                ptr      <= shreg;
                                first_wr <= 1'b0;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 8'd1;
                            end
                        end else if (bitcnt == 4'd9) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                    LS_RD: begin
                        if (bitcnt < 4'd8) begin
                            sda_oe <= ~txb[7];
                        end else if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            if (!is_ara) ptr <= ptr + 8'd1;
                        end else if (!shreg[0]) begin
                            bitcnt  <= '0;
                            txb     <= next_tx;
                            sda_oe  <= ~next_tx[7];
                            stat_rd <= !is_ara && (ptr == STAT_ADDR);
                        end else begin
                            st     <= LS_HOLD;
                            sda_oe <= 1'b0;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_alert_target.sv
// Module: top of the SMBus target with alert response, inactivity timeout and lock.
// Assumes: the open-drain wires are resolved outside; scl_i/sda_i are the wire levels.
module smb_alert_target #(
    parameter int         CLK_HZ     = 50_000_000,
    parameter int         TIMEOUT_MS = 35,
    parameter logic [6:0] DEV_ADDR   = 7'h2E,
    parameter int         NRES       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic             alert_oe,
    input  logic [7:0]       status_in,
    input  logic [NRES*8-1:0] result_in
);
    localparam int         TMO_CYCLES = CLK_HZ / 1000 * TIMEOUT_MS;
    localparam logic [7:0] STAT_ADDR  = 8'h41;

    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev, edge_ev, tmo_ev;
    logic       busy, wr_en, stat_rd, alert, tmo_dis, cfg_lock;
    logic [7:0] ptr, wr_addr, wr_data, rd_data;

    smb_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
        .stop_ev(stop_ev), .edge_ev(edge_ev)
    );

    smb_timeout #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .busy(busy), .edge_ev(edge_ev),
        .enable(!tmo_dis), .tmo_ev(tmo_ev)
    );

    smb_link #(.DEV_ADDR(DEV_ADDR), .STAT_ADDR(STAT_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .tmo_ev(tmo_ev), .alert(alert), .rd_data(rd_data), .sda_oe(sda_oe),
        .busy(busy), .wr_en(wr_en), .stat_rd(stat_rd), .ptr(ptr),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    smb_regs #(.NRES(NRES), .STAT_ADDR(STAT_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ptr), .stat_rd(stat_rd),
        .status_in(status_in), .result_in(result_in), .rd_data(rd_data),
        .alert(alert), .tmo_dis(tmo_dis), .cfg_lock(cfg_lock)
    );

    assign alert_oe = alert;
endmodule

// File: rtl/smb_alert_target_chk.sv
// Module: property checker bound to smb_alert_target.
// Assumes: inputs follow the bus rules stated in the brief.
module smb_alert_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       alert_oe,
    input logic [7:0] status_in,
    input logic       stop_ev,
    input logic       tmo_ev,
    input logic       tmo_dis,
    input logic       cfg_lock
);
    // alert can only start after some condition input was high
    assert_alert_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_oe) |-> $past(status_in != 8'h00));

    // the bus is free after a STOP
    assert_release_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // timeout frees SDA
    assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_ev |=> !sda_oe);

    // no timeout while it is disabled
    assert_timeout_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_ev |-> !$past(tmo_dis));

    // lock never clears before reset
    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> cfg_lock);
endmodule

bind smb_alert_target smb_alert_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .alert_oe(alert_oe),
    .status_in(status_in), .stop_ev(stop_ev), .tmo_ev(tmo_ev),
    .tmo_dis(tmo_dis), .cfg_lock(cfg_lock)
);

// File: tb/smb_alert_target_test.sv
module smb_alert_target_test;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 10;
    localparam int         HZ         = 100_000;
    localparam int         TMO        = HZ / 1000 * 35;
    localparam logic [6:0] DEV        = 7'h2E;
    localparam logic [6:0] ARA        = 7'h0C;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1, rival_sda = 1'b1;
    logic [7:0]  status_in = 8'h00;
    logic [39:0] result_in = 40'h55_44_33_22_11;
    logic        sda_oe, alert_oe, sda_line;
    int          checks = 0, fails = 0;

    assign sda_line = m_sda & rival_sda & ~sda_oe;
    always #(CLK_PERIOD / 2) clk = ~clk;

    smb_alert_target #(.CLK_HZ(HZ), .DEV_ADDR(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .alert_oe(alert_oe), .status_in(status_in),
        .result_in(result_in)
    );

    // {req[3:0], write, reg[7:0], value[7:0]}
    localparam logic [20:0] VEC [12] = '{
        {4'd3,  1'b0, 8'h20, 8'h11},
        {4'd3,  1'b0, 8'h24, 8'h55},
        {4'd1,  1'b0, 8'h40, 8'h00},
        {4'd1,  1'b0, 8'h42, 8'hFF},
        {4'd2,  1'b1, 8'h42, 8'h5A},
        {4'd2,  1'b0, 8'h42, 8'h5A},
        {4'd3,  1'b1, 8'h20, 8'hEE},
        {4'd3,  1'b0, 8'h20, 8'h11},
        {4'd11, 1'b1, 8'h40, 8'h00},
        {4'd11, 1'b0, 8'h40, 8'h00},
        {4'd5,  1'b0, 8'h41, 8'h00},
        {4'd3,  1'b0, 8'h30, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); m_sda = 1; m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
    task automatic bus_stop(); m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); endtask
    task automatic wbit(input logic b); m_sda = b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq(); endtask
    task automatic rbit(output logic b, input logic rb);
        m_sda = 1; rival_sda = rb; wq(); m_scl = 1; wq(); b = sda_line; wq(); m_scl = 0; wq();
    endtask
    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b, 1'b1);
        ack = !b;
    endtask
    task automatic rbyte(output logic [7:0] d, input logic [7:0] rv, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin rbit(b, rv[i]); d[i] = b; end
        rival_sda = 1;
        wbit(!mack);
        m_sda = 1;
    endtask
    task automatic set_ptr(input logic [7:0] r);
        logic a;
        bus_start(); wbyte({DEV, 1'b0}, a); wbyte(r, a); bus_stop();
    endtask
    task automatic reg_write(input logic [7:0] r, input logic [7:0] d);
        logic a;
        bus_start(); wbyte({DEV, 1'b0}, a); wbyte(r, a); wbyte(d, a); bus_stop();
    endtask
    task automatic reg_read(input logic [7:0] r, output logic [7:0] d);
        logic a;
        set_ptr(r);
        bus_start(); wbyte({DEV, 1'b1}, a); rbyte(d, 8'hFF, 1'b0); bus_stop();
    endtask
    task automatic settle(); repeat (4) @(negedge clk); endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       a;
        repeat (5) @(negedge clk);
        rst_n = 1;
        settle();
        chk("R1 sda released", sda_oe, 0);
        chk("R1 alert released", alert_oe, 0);

        // table walk
        for (int k = 0; k < 12; k++) begin
            if (VEC[k][16]) reg_write(VEC[k][15:8], VEC[k][7:0]);
            else begin
                reg_read(VEC[k][15:8], d);
                chk($sformatf("R%0d table %0d", VEC[k][20:17], k), d, VEC[k][7:0]);
            end
        end

        // R2: multi-byte write across read-only status into mask
        bus_start(); wbyte({DEV, 1'b0}, a); chk("R2 addr ack", a, 1);
        wbyte(8'h41, a); wbyte(8'hAA, a); chk("R2 data ack", a, 1);
        wbyte(8'h0F, a); bus_stop();
        reg_read(8'h42, d); chk("R2 auto-increment write", d, 8'h0F);

        // R3: auto-increment read
        set_ptr(8'h22);
        bus_start(); wbyte({DEV, 1'b1}, a);
        rbyte(d, 8'hFF, 1'b1); chk("R3 burst byte0", d, 8'h33);
        rbyte(d, 8'hFF, 1'b1); chk("R3 burst byte1", d, 8'h44);
        rbyte(d, 8'hFF, 1'b0); chk("R3 burst byte2", d, 8'h55);
        bus_stop();

        // R4: foreign address
        bus_start(); wbyte({7'h33, 1'b0}, a); bus_stop();
        chk("R4 foreign address nack", a, 0);

        // R6: ARA without alert
        bus_start(); wbyte({ARA, 1'b1}, a); bus_stop();
        chk("R6 ARA nack when idle", a, 0);

        // R5: masked condition
        status_in = 8'h80; settle();
        chk("R5 masked bit no alert", alert_oe, 0);
        status_in = 8'h01; settle();
        chk("R5 enabled bit alerts", alert_oe, 1);

        // R6: ARA response
        bus_start(); wbyte({ARA, 1'b1}, a); chk("R6 ARA ack", a, 1);
        rbyte(d, 8'hFF, 1'b0); bus_stop();
        chk("R6 ARA returns address", d, {DEV, 1'b0});
        chk("R8 alert held after ARA", alert_oe, 1);
        status_in = 8'h00; settle();
        chk("R8 alert held after condition drops", alert_oe, 1);
        reg_read(8'h41, d);
        chk("R8 status read value", d, 8'h81);
        settle();
        chk("R8 alert released after read", alert_oe, 0);

        // R7: arbitration against lower address 0x10
        status_in = 8'h02; settle();
        bus_start(); wbyte({ARA, 1'b1}, a);
        rbyte(d, {7'h10, 1'b0}, 1'b0); bus_stop();
        chk("R7 lower address wins", d, {7'h10, 1'b0});
        chk("R7 sda released after loss", sda_oe, 0);
        chk("R7 alert kept after loss", alert_oe, 1);
        reg_read(8'h41, d);
        chk("R8 status keeps live bit", d, 8'h02);
        chk("R8 alert stays while live", alert_oe, 1);
        status_in = 8'h00;
        reg_read(8'h41, d); settle();
        chk("R8 alert cleared", alert_oe, 0);

        // R9: timeout enabled
        set_ptr(8'h20);
        bus_start(); wbyte({DEV, 1'b1}, a); settle();
        chk("R9 driving first bit", sda_oe, 1);
        repeat (TMO + 100) @(negedge clk);
        chk("R9 released after timeout", sda_oe, 0);
        bus_stop();

        // R10: timeout disabled
        reg_write(8'h40, 8'h40);
        set_ptr(8'h20);
        bus_start(); wbyte({DEV, 1'b1}, a);
        repeat (TMO + 400) @(negedge clk);
        chk("R10 still driving when disabled", sda_oe, 1);
        rbyte(d, 8'hFF, 1'b0); bus_stop();
        chk("R10 byte intact after stall", d, 8'h11);

        // R11: lock
        reg_write(8'h40, 8'h42);
        reg_read(8'h40, d); chk("R11 lock readback", d, 8'h42);
        reg_write(8'h42, 8'hFF);
        reg_read(8'h42, d); chk("R11 mask frozen", d, 8'h0F);
        reg_write(8'h40, 8'h00);
        reg_read(8'h40, d); chk("R11 lock not clearable", d, 8'h42);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule